// File: doc/BRIEF.md
# Always-On Countdown Timer With Periodic and One-Shot Modes

This block is one timer channel for an always-powered domain. When processors are asleep and their local timers are off, it raises an interrupt to wake them. Software reaches it over a small 32-bit register bus and sets it up in three steps: stop the timer, write a 64-bit start value as two 32-bit halves, then write the control word with the run bit set.

While it runs, a 64-bit counter counts down by one on every clock. When it reaches zero it sets a sticky status flag. The interrupt line is that flag gated by an unmask bit, and it is active-high and level-sensitive. In periodic mode the counter reloads and keeps going, so one period is the load value plus one cycles. In one-shot mode it stops at zero until software stops the timer and starts it again. Software removes the flag by writing a one to the status register.

Top module: `cdt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: The low load word at offset 0x00 and the high load word at offset 0x04 read back all 32 bits as written. The control register at offset 0x10 reads back bits [2:0] (bit 0 run, bit 1 one-shot mode, bit 2 unmask), and its bits above bit 2 read zero.
- R3: Reads of any offset other than 0x00, 0x04, 0x10 and 0x18 return zero. Writes to those offsets change no register.
- R4: In one-shot mode (control bit 1 = 1), the status flag sets on the clock edge load+2 cycles after the edge that writes the run bit to 1. This holds for a load of zero. After that expiry there is no further one until the timer is stopped and started again.
- R5: In periodic mode (control bit 1 = 0), the first expiry comes as in R4. Each later expiry follows the one before it by load+1 cycles.
- R6: The counter is 64 bits wide, and the word at 0x04 is its upper half. With a nonzero high word, no expiry comes near the time that the low word alone would give.
- R7: The status flag at offset 0x18, bit 0, sets on expiry even when the unmask bit is 0. `irq_o` equals the status flag ANDed with control bit 2, so unmasking later raises `irq_o`.
- R8: A write to 0x18 with bit 0 = 1 clears the status flag and drops `irq_o`. A write to 0x18 with bit 0 = 0 leaves the flag as it is.
- R9: If a clearing write and an expiry land on the same clock edge, the status flag stays set.
- R10: Writing zero to the control register stops the counter, so no further expiry comes. A status flag that is already set stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte offset in the 32-byte window |
| bus_we | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench runs the count with a one-shot load of ten and a one-shot load of zero, which separates an off-by-one in the start latency from an off-by-one in the compare. A periodic run over three expiries shows whether the reload adds a cycle. A load with a nonzero high word shows whether the upper half really feeds the counter. A clearing write placed on the exact edge of an expiry, and a run with the interrupt masked, separate the priority of the status flag from the gating of the interrupt line.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 5'h18;

  // Control word, bit 0 run, bit 1 one-shot, bit 2 unmask
  typedef struct packed {
    logic unmask;
    logic oneshot;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cdt_regfile.sv
module cdt_regfile
  import cdt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          stat,
  output ctrl_t         ctrl,
  output logic [2*DW-1:0] load,
  output logic          clr_req
);
  logic [DW-1:0] load_lo, load_hi;
  logic sel_lo, sel_hi, sel_ctrl, sel_stat;

  assign sel_lo   = (bus_addr == AW'(OFS_LOAD_LO));
  assign sel_hi   = (bus_addr == AW'(OFS_LOAD_HI));
  assign sel_ctrl = (bus_addr == AW'(OFS_CTRL));
  assign sel_stat = (bus_addr == AW'(OFS_STAT));

  assign clr_req = bus_we && sel_stat && bus_wdata[0];
  assign load    = {load_hi, load_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_lo <= '0;
      load_hi <= '0;
      ctrl    <= '0;
    end else if (bus_we) begin
      if (sel_lo)   load_lo <= bus_wdata;
      if (sel_hi)   load_hi <= bus_wdata;
      if (sel_ctrl) ctrl    <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_lo)   bus_rdata = load_lo;
    if (sel_hi)   bus_rdata = load_hi;
    if (sel_ctrl) bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
    if (sel_stat) bus_rdata = {{(DW-1){1'b0}}, stat};
  end

  // R3: an unused offset reads zero
  p_unused_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_lo || sel_hi || sel_ctrl || sel_stat) |-> bus_rdata == '0);

  // R3: a write to an unused offset leaves the load words unchanged
  p_unused_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(sel_lo || sel_hi || sel_ctrl)) |=> $stable(load) && $stable(ctrl));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          oneshot,
  input  logic [CW-1:0] load,
  output logic          expire
);
  logic [CW-1:0] cnt;
  logic          run_q;
  logic          done;
  logic          start;
  logic          at_zero;

  function automatic logic [CW-1:0] next_count(
    input logic [CW-1:0] cur,
    input logic [CW-1:0] ld,
    input logic          st,
    input logic          one);
    if (st)               return ld;
    else if (cur == '0)   return one ? '0 : ld;
    else                  return cur - CW'(1);
  endfunction

  assign start   = run && !run_q;
  assign at_zero = (cnt == '0);
  assign expire  = run && run_q && at_zero && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      run_q <= run;
      if (!run) begin
        cnt  <= '0;
        done <= 1'b0;
      end else begin
        cnt <= next_count(cnt, load, start, oneshot);
        if (start)                      done <= 1'b0;
        else if (at_zero && oneshot)    done <= 1'b1;
      end
    end
  end

  // R4: a start takes the load value
  p_start_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == $past(load));

  // R4: a running nonzero count steps down by one
  p_counts_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_q && !at_zero && $past(run)) |=> (!run || cnt == $past(cnt) - CW'(1)));

  // R4: one-shot mode expires once per start
  p_oneshot_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && oneshot && run) |=> !expire);

  // R5: periodic mode reloads after the zero cycle
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !oneshot && run) |=> (!run || cnt == $past(load)));

  // R10: a stopped counter never expires in the next cycle
  p_stopped_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !expire);
endmodule

// File: rtl/cdt_status.sv
module cdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  input  logic unmask,
  output logic stat,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat <= 1'b0;
    else if (expire)  stat <= 1'b1;
    else if (clr_req) stat <= 1'b0;
  end

  assign irq = stat && unmask;

  // R9: expiry beats a simultaneous clear
  p_expiry_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat);

  // R8: a clear with no expiry drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !stat);

  // R7: a masked expiry still sets the flag
  p_masked_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !unmask) |=> stat);

  // R10: the flag stays set without a clear
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat && !clr_req) |=> stat);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int unsigned CW = 2 * DW;

  ctrl_t         ctrl;
  logic [CW-1:0] load;
  logic          clr_req;
  logic          expire;
  logic          stat;

  cdt_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stat      (stat),
    .ctrl      (ctrl),
    .load      (load),
    .clr_req   (clr_req)
  );

  cdt_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .oneshot (ctrl.oneshot),
    .load    (load),
    .expire  (expire)
  );

  cdt_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .clr_req (clr_req),
    .unmask  (ctrl.unmask),
    .stat    (stat),
    .irq     (irq_o)
  );

  // R7: the line is never high while masked
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.unmask |-> !irq_o);
endmodule

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic rd_pend = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];

  cdt_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data against the scoreboard queue
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rd_pend && sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      chk({32'h0, bus_rdata}, {32'h0, it.exp}, it.tag);
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a;
    bus_we = 1'b0;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
    rd_pend = 1'b1;
    @(negedge clk);
    rd_pend = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output int edge_cyc);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    edge_cyc = cyc;
  endtask

  task automatic wait_irq(input int limit, output int seen);
    seen = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      #1;
      if (irq_o) begin
        seen = cyc;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c0;
    int seen;
    int dummy;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(5'h00, 32'h0, "R1 load_lo after reset");
    rd(5'h04, 32'h0, "R1 load_hi after reset");
    rd(5'h10, 32'h0, "R1 ctrl after reset");
    rd(5'h18, 32'h0, "R1 status after reset");
    chk(64'(irq_o), 64'h0, "R1 irq after reset");

    // R2: readback
    wr(5'h00, 32'hA5A5_1234, dummy);
    wr(5'h04, 32'h0000_00C3, dummy);
    rd(5'h00, 32'hA5A5_1234, "R2 load_lo readback");
    rd(5'h04, 32'h0000_00C3, "R2 load_hi readback");
    wr(5'h10, 32'hFFFF_FFF8, dummy);
    rd(5'h10, 32'h0, "R2 ctrl upper bits read zero");
    wr(5'h10, 32'h0000_0006, dummy);
    rd(5'h10, 32'h6, "R2 ctrl low bits readback");
    wr(5'h10, 32'h0, dummy);

    // R3: unused offsets
    wr(5'h08, 32'hFFFF_FFFF, dummy);
    wr(5'h0C, 32'hFFFF_FFFF, dummy);
    wr(5'h1C, 32'hFFFF_FFFF, dummy);
    rd(5'h08, 32'h0, "R3 unused offset reads zero");
    rd(5'h1C, 32'h0, "R3 unused offset 0x1C reads zero");
    rd(5'h00, 32'hA5A5_1234, "R3 load_lo untouched");
    rd(5'h04, 32'h0000_00C3, "R3 load_hi untouched");
    rd(5'h10, 32'h0, "R3 ctrl untouched");
    rd(5'h18, 32'h0, "R3 status untouched");

    // R6: high word feeds the counter
    wr(5'h04, 32'h1, dummy);
    wr(5'h00, 32'h3, dummy);
    wr(5'h10, 32'h7, c0);
    idle(300);
    chk(64'(irq_o), 64'h0, "R6 high word delays expiry (irq)");
    rd(5'h18, 32'h0, "R6 high word delays expiry (status)");
    wr(5'h10, 32'h0, dummy);
    wr(5'h04, 32'h0, dummy);

    // R4: one-shot load 10
    wr(5'h00, 32'd10, dummy);
    wr(5'h10, 32'h7, c0);
    wait_irq(200, seen);
    chk(64'(seen), 64'(c0 + 12), "R4 one-shot expiry cycle load=10");
    // R8: write of zero keeps the flag
    wr(5'h18, 32'h0, dummy);
    rd(5'h18, 32'h1, "R8 zero write keeps status");
    wr(5'h18, 32'h1, dummy);
    rd(5'h18, 32'h0, "R8 one write clears status");
    chk(64'(irq_o), 64'h0, "R8 irq drops after clear");
    idle(100);
    rd(5'h18, 32'h0, "R4 one-shot no second expiry");

    // R4: one-shot load 0
    wr(5'h10, 32'h0, dummy);
    wr(5'h00, 32'd0, dummy);
    wr(5'h10, 32'h7, c0);
    wait_irq(50, seen);
    chk(64'(seen), 64'(c0 + 2), "R4 one-shot expiry cycle load=0");
    wr(5'h18, 32'h1, dummy);

    // R5: periodic load 10
    wr(5'h10, 32'h0, dummy);
    wr(5'h00, 32'd10, dummy);
    wr(5'h10, 32'h5, c0);
    wait_irq(200, seen);
    chk(64'(seen), 64'(c0 + 12), "R5 periodic first expiry");
    wr(5'h18, 32'h1, dummy);
    wait_irq(200, seen);
    chk(64'(seen), 64'(c0 + 23), "R5 periodic second expiry");
    wr(5'h18, 32'h1, dummy);
    wait_irq(200, seen);
    chk(64'(seen), 64'(c0 + 34), "R5 periodic third expiry");

    // R9: clear lands on the edge of the fourth expiry (c0+45)
    while (cyc < c0 + 44) @(negedge clk);
    bus_addr = 5'h18;
    bus_wdata = 32'h1;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(5'h18, 32'h1, "R9 expiry wins over clear");

    // R7: masked one-shot
    wr(5'h10, 32'h0, dummy);
    wr(5'h18, 32'h1, dummy);
    wr(5'h00, 32'd5, dummy);
    wr(5'h10, 32'h3, c0);
    idle(20);
    chk(64'(irq_o), 64'h0, "R7 masked expiry keeps irq low");
    rd(5'h18, 32'h1, "R7 masked expiry sets status");
    wr(5'h10, 32'h7, dummy);
    #1;
    chk(64'(irq_o), 64'h1, "R7 unmask raises irq");

    // R10: stop leaves flag, no further expiry
    wr(5'h10, 32'h0, dummy);
    wr(5'h18, 32'h1, dummy);
    wr(5'h00, 32'd10, dummy);
    wr(5'h10, 32'h5, c0);
    wait_irq(200, seen);
    chk(64'(seen), 64'(c0 + 12), "R10 expiry before stop");
    wr(5'h10, 32'h0, dummy);
    rd(5'h18, 32'h1, "R10 status stays set after stop");
    wr(5'h18, 32'h1, dummy);
    idle(60);
    rd(5'h18, 32'h0, "R10 no expiry after stop");

    idle(2);
    finish_run();
  end
endmodule